// File: doc/BRIEF.md
# Reorder Buffer Retirement Controller

This block holds in-flight instructions of an out-of-order core in a circular reorder buffer and retires them in program order. Each instruction is only a small tag record: a sequence number and flags for control flow, fault, non-speculative handling and an early kill. A dispatch port writes up to two renamed instructions per cycle at the tail. An execute port reports finished instructions by sequence number, and the block marks the matching entries as able to commit. Each cycle the controller looks at the oldest entries and retires those that are finished. It stops at the first entry that is not ready, and it never commits more than the commit width.

When execute reports a mispredict, the controller stops dispatch and commit. It then walks back from the tail, dropping a bounded number of younger entries per cycle, and returns to normal operation once none remain. Every cycle it reports status to earlier stages. This status gives the free entry count and the last done sequence number. It also carries a squash pulse, a flag that shows a squash walk is in progress, the mispredict fields passed through from execute, and a release request for a non-speculative head instruction that still has to execute. All outputs except `disp_ready` are registered. They show the result of the previous clock edge.

Top module: `rob_retire_top`

## Requirements
- R1: Instructions retire strictly in dispatch order. Slot 0 of `ret_valid`/`ret_seq` (bits 15:0) holds the older instruction, and slot 1 is used only with slot 0. At most 2 real instructions retire per cycle. Retirement stops at the first live head entry that has not been reported complete.
- R2: A head entry killed through `cpl_kill` is dropped without appearing on the retire port. It adds nothing to the branch count, raises no trap and does not count toward the 2-per-cycle limit. At most 4 head entries are examined per cycle.
- R3: A non-speculative head entry that has not completed produces one `rel_valid` pulse carrying its sequence number, one cycle after it reaches the head. Retirement stops there. No further request follows, and the entry retires only after execute reports it complete.
- R4: In the cycle after `sq_req` is taken, `bk_squash` and `bk_squashing` are 1 and `done_seq` equals `sq_seq`. `bk_mispred`, `bk_taken`, `bk_next_pc` and `bk_bad_pc` equal the inputs given with the request.
- R5: While squashing, no dispatch and no commit occur. Each cycle up to 2 entries with sequence numbers above the squash point are removed, youngest first. `done_seq` then shows the new youngest entry, or the squash point if the buffer is empty. The first cycle that finds no younger entry clears `bk_squashing`, and normal operation resumes in the next cycle.
- R6: `disp_ready` is 1 only when the controller is not squashing, no `sq_req` is present and at least 2 entries are free. Up to 2 instructions are taken per cycle. A slot with `disp_skip` set takes no entry.
- R7: Completion reports mark the matching entry every cycle, including cycles spent squashing.
- R8: `free_count` shows the number of empty entries (16 after reset). After a cycle that retires instructions, `done_seq` shows the youngest instruction retired in that cycle.
- R9: Retiring a faulted entry raises `trap_valid` with its sequence number for one cycle. Each retired control-flow entry adds one to `branch_count`.
- R10: After reset the buffer is empty, `free_count` is 16, `disp_ready` is 1, and all pulses, flags, `done_seq` and `branch_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 2 | Dispatch slot valid |
| disp_seq | input | 32 | Sequence numbers, slot k at bits 16k+15:16k |
| disp_skip | input | 2 | Slot already squashed, do not insert |
| disp_nonspec | input | 2 | Slot must execute non-speculatively |
| disp_ctrl | input | 2 | Slot is a control-flow instruction |
| disp_fault | input | 2 | Slot carries a fault |
| disp_ready | output | 1 | Dispatch group accepted this cycle |
| cpl_valid | input | 2 | Completion report valid |
| cpl_seq | input | 32 | Completed sequence numbers |
| cpl_kill | input | 2 | Completed entry is to be discarded |
| sq_req | input | 1 | Squash request from execute |
| sq_seq | input | 16 | Squash point; younger entries are removed |
| sq_mispred | input | 1 | Squash is a branch mispredict |
| sq_taken | input | 1 | Branch direction |
| sq_next_pc | input | 32 | Corrected fetch address |
| sq_bad_pc | input | 32 | Address of the mispredicted branch |
| ret_valid | output | 2 | Retire slot valid |
| ret_seq | output | 32 | Retired sequence numbers |
| trap_valid | output | 1 | A faulted instruction retired |
| trap_seq | output | 16 | Sequence number of the faulted instruction |
| rel_valid | output | 1 | Non-speculative release request |
| rel_seq | output | 16 | Sequence number to release |
| branch_count | output | 16 | Retired control-flow instructions |
| free_count | output | 5 | Empty buffer entries |
| done_seq | output | 16 | Last retired or squash-related sequence number |
| bk_squash | output | 1 | Squash pulse to earlier stages |
| bk_squashing | output | 1 | Squash walk in progress |
| bk_mispred | output | 1 | Passed-through mispredict flag |
| bk_taken | output | 1 | Passed-through branch direction |
| bk_next_pc | output | 32 | Passed-through corrected address |
| bk_bad_pc | output | 32 | Passed-through branch address |

## Verification
The assertions assume that sequence numbers rise strictly with dispatch order and never wrap. They also assume that `sq_req` never arrives while a walk is in progress, and that every completion or kill names exactly one live entry. The stimulus hands out sequence numbers from one counter that only increases. It issues one squash at a time and waits for `bk_squashing` to fall. It reports each instruction only once, and kills only entries that have not retired. Dispatch is offered during a walk on purpose, to show that it is refused.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_DEPTH    = 16;
    localparam int ROB_COMMIT_W = 2;
    localparam int ROB_RENAME_W = 2;
    localparam int ROB_EXEC_W   = 2;
    localparam int ROB_WALK_W   = 2;
    localparam int ROB_PC_W     = 32;
    localparam int ROB_BR_W     = 16;
    localparam int SEQ_W        = 16;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef enum logic {ST_RUN, ST_SQUASH} rob_state_e;

    typedef struct packed {
        logic valid;
        logic killed;
        logic can_commit;
        logic executed;
        logic nonspec;
        logic ctrl;
        logic fault;
        seq_t seq;
    } rob_entry_t;

    function automatic logic seq_is_younger(seq_t a, seq_t b);
        return a > b;
    endfunction

endpackage

// File: rtl/rob_commit_scan.sv
module rob_commit_scan
    import rob_pkg::*;
#(
    parameter int COMMIT_W = ROB_COMMIT_W,
    parameter int SCAN     = COMMIT_W + 2,
    parameter int OCC_W    = 5
)(
    input  rob_entry_t                      win [SCAN],
    input  logic [OCC_W-1:0]                occ,
    output logic [$clog2(SCAN+1)-1:0]       n_pop,
    output logic [COMMIT_W-1:0]             ret_v,
    output seq_t                            ret_s [COMMIT_W],
    output logic                            rel_v,
    output logic [$clog2(SCAN)-1:0]         rel_off,
    output seq_t                            rel_s,
    output logic                            trap_v,
    output seq_t                            trap_s,
    output logic [$clog2(COMMIT_W+1)-1:0]   n_br,
    output seq_t                            last_s
);
    localparam int POP_W = $clog2(SCAN+1);
    localparam int OFF_W = $clog2(SCAN);
    localparam int BRC_W = $clog2(COMMIT_W+1);

    always_comb begin
        int   pop;
        int   cm;
        int   br;
        logic stop;
        pop = 0; cm = 0; br = 0; stop = 1'b0;
        ret_v = '0; rel_v = 1'b0; rel_off = '0; rel_s = '0;
        trap_v = 1'b0; trap_s = '0; last_s = '0;
        for (int c = 0; c < COMMIT_W; c++) ret_s[c] = '0;
        for (int i = 0; i < SCAN; i++) begin
            if (!stop) begin
                if (i >= int'(occ) || !win[i].valid || cm == COMMIT_W) begin
                    stop = 1'b1;
                end else if (win[i].killed) begin
                    pop++;
                end else if (!win[i].can_commit) begin
                    stop = 1'b1;
                end else if (!win[i].executed) begin
                    stop = 1'b1;
                    if (win[i].nonspec) begin
                        rel_v   = 1'b1;
                        rel_off = OFF_W'(i);
                        rel_s   = win[i].seq;
                    end
                end else begin
                    ret_v[cm] = 1'b1;
                    ret_s[cm] = win[i].seq;
                    last_s    = win[i].seq;
                    cm++;
                    pop++;
                    if (win[i].ctrl) br++;
                    if (win[i].fault && !trap_v) begin
                        trap_v = 1'b1;
                        trap_s = win[i].seq;
                    end
                end
            end
        end
        n_pop = POP_W'(pop);
        n_br  = BRC_W'(br);
    end

endmodule

// File: rtl/rob_squash_walk.sv
module rob_squash_walk
    import rob_pkg::*;
#(
    parameter int WALK_W = ROB_WALK_W,
    parameter int OCC_W  = 5
)(
    input  seq_t                           tail_seqs [WALK_W+1],
    input  logic [OCC_W-1:0]               occ,
    input  seq_t                           sq_point,
    output logic [$clog2(WALK_W+1)-1:0]    n_rm,
    output seq_t                           tail_s
);
    localparam int RM_W = $clog2(WALK_W+1);

    always_comb begin
        int   rm;
        logic stop;
        rm = 0; stop = 1'b0;
        for (int j = 0; j < WALK_W; j++) begin
            if (!stop) begin
                if (j < int'(occ) && seq_is_younger(tail_seqs[j], sq_point)) rm++;
                else stop = 1'b1;
            end
        end
        n_rm   = RM_W'(rm);
        tail_s = (int'(occ) > rm) ? tail_seqs[rm] : sq_point;
    end

endmodule

// File: rtl/rob_retire_top.sv
module rob_retire_top
    import rob_pkg::*;
#(
    parameter int DEPTH    = ROB_DEPTH,
    parameter int COMMIT_W = ROB_COMMIT_W,
    parameter int RENAME_W = ROB_RENAME_W,
    parameter int EXEC_W   = ROB_EXEC_W,
    parameter int WALK_W   = ROB_WALK_W,
    parameter int PC_W     = ROB_PC_W,
    parameter int BR_W     = ROB_BR_W
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [RENAME_W-1:0]         disp_valid,
    input  logic [RENAME_W*SEQ_W-1:0]   disp_seq,
    input  logic [RENAME_W-1:0]         disp_skip,
    input  logic [RENAME_W-1:0]         disp_nonspec,
    input  logic [RENAME_W-1:0]         disp_ctrl,
    input  logic [RENAME_W-1:0]         disp_fault,
    output logic                        disp_ready,
    input  logic [EXEC_W-1:0]           cpl_valid,
    input  logic [EXEC_W*SEQ_W-1:0]     cpl_seq,
    input  logic [EXEC_W-1:0]           cpl_kill,
    input  logic                        sq_req,
    input  logic [SEQ_W-1:0]            sq_seq,
    input  logic                        sq_mispred,
    input  logic                        sq_taken,
    input  logic [PC_W-1:0]             sq_next_pc,
    input  logic [PC_W-1:0]             sq_bad_pc,
    output logic [COMMIT_W-1:0]         ret_valid,
    output logic [COMMIT_W*SEQ_W-1:0]   ret_seq,
    output logic                        trap_valid,
    output logic [SEQ_W-1:0]            trap_seq,
    output logic                        rel_valid,
    output logic [SEQ_W-1:0]            rel_seq,
    output logic [BR_W-1:0]             branch_count,
    output logic [$clog2(DEPTH):0]      free_count,
    output logic [SEQ_W-1:0]            done_seq,
    output logic                        bk_squash,
    output logic                        bk_squashing,
    output logic                        bk_mispred,
    output logic                        bk_taken,
    output logic [PC_W-1:0]             bk_next_pc,
    output logic [PC_W-1:0]             bk_bad_pc
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;
    localparam int SCAN  = COMMIT_W + 2;
    localparam int POP_W = $clog2(SCAN+1);
    localparam int OFF_W = $clog2(SCAN);
    localparam int RM_W  = $clog2(WALK_W+1);
    localparam int BRC_W = $clog2(COMMIT_W+1);
    localparam int INS_W = $clog2(RENAME_W+1);

    rob_entry_t         mem [DEPTH];
    rob_state_e         state_q;
    logic [PTR_W-1:0]   head_q, tail_q, occ, occ_next;
    logic [IDX_W-1:0]   head_idx, tail_idx;

    assign occ      = tail_q - head_q;
    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign disp_ready = (state_q == ST_RUN) && !sq_req &&
                        ((PTR_W'(DEPTH) - occ) >= PTR_W'(RENAME_W));

    // Windows onto the oldest and youngest entries
    rob_entry_t hwin [SCAN];
    seq_t       tseq [WALK_W+1];
    for (genvar i = 0; i < SCAN; i++) begin : g_hwin
        assign hwin[i] = mem[head_idx + IDX_W'(i)];
    end
    for (genvar j = 0; j <= WALK_W; j++) begin : g_twin
        assign tseq[j] = mem[tail_idx - IDX_W'(j+1)].seq;
    end

    logic [POP_W-1:0]    n_pop;
    logic [COMMIT_W-1:0] sc_ret_v;
    seq_t                sc_ret_s [COMMIT_W];
    logic                sc_rel_v, sc_trap_v;
    logic [OFF_W-1:0]    sc_rel_off;
    seq_t                sc_rel_s, sc_trap_s, sc_last_s;
    logic [BRC_W-1:0]    sc_n_br;

    rob_commit_scan #(.COMMIT_W(COMMIT_W), .SCAN(SCAN), .OCC_W(PTR_W)) u_scan (
        .win(hwin), .occ(occ), .n_pop(n_pop), .ret_v(sc_ret_v), .ret_s(sc_ret_s),
        .rel_v(sc_rel_v), .rel_off(sc_rel_off), .rel_s(sc_rel_s),
        .trap_v(sc_trap_v), .trap_s(sc_trap_s), .n_br(sc_n_br), .last_s(sc_last_s)
    );

    logic [RM_W-1:0] w_rm;
    seq_t            w_tail_s, sq_point_q;

    rob_squash_walk #(.WALK_W(WALK_W), .OCC_W(PTR_W)) u_walk (
        .tail_seqs(tseq), .occ(occ), .sq_point(sq_point_q),
        .n_rm(w_rm), .tail_s(w_tail_s)
    );

    // Dispatch slot placement
    logic [RENAME_W-1:0] ins_en;
    logic [IDX_W-1:0]    ins_idx [RENAME_W];
    logic [INS_W-1:0]    n_ins;

    always_comb begin
        int c;
        c = 0;
        for (int k = 0; k < RENAME_W; k++) begin
            ins_en[k]  = disp_ready && disp_valid[k] && !disp_skip[k];
            ins_idx[k] = tail_idx + IDX_W'(c);
            if (ins_en[k]) c++;
        end
        n_ins = INS_W'(c);
    end

    always_comb begin
        if (state_q == ST_RUN) begin
            if (sq_req) occ_next = occ;
            else        occ_next = occ - PTR_W'(n_pop) + PTR_W'(n_ins);
        end else begin
            occ_next = occ - PTR_W'(w_rm);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0; tail_q <= '0; state_q <= ST_RUN; sq_point_q <= '0;
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
            ret_valid <= '0; ret_seq <= '0; trap_valid <= 1'b0; trap_seq <= '0;
            rel_valid <= 1'b0; rel_seq <= '0; branch_count <= '0;
            free_count <= PTR_W'(DEPTH); done_seq <= '0;
            bk_squash <= 1'b0; bk_squashing <= 1'b0; bk_mispred <= 1'b0;
            bk_taken <= 1'b0; bk_next_pc <= '0; bk_bad_pc <= '0;
        end else begin
            ret_valid <= '0; trap_valid <= 1'b0; rel_valid <= 1'b0; bk_squash <= 1'b0;
            free_count <= PTR_W'(DEPTH) - occ_next;
            if (state_q == ST_RUN) begin
                if (sq_req) begin
                    state_q <= ST_SQUASH; sq_point_q <= sq_seq;
                    bk_squash <= 1'b1; bk_squashing <= 1'b1; done_seq <= sq_seq;
                    bk_mispred <= sq_mispred; bk_taken <= sq_taken;
                    bk_next_pc <= sq_next_pc; bk_bad_pc <= sq_bad_pc;
                end else begin
                    head_q <= head_q + PTR_W'(n_pop);
                    for (int i = 0; i < SCAN; i++)
                        if (i < int'(n_pop)) mem[head_idx + IDX_W'(i)].valid <= 1'b0;
                    ret_valid <= sc_ret_v;
                    for (int c = 0; c < COMMIT_W; c++) ret_seq[c*SEQ_W +: SEQ_W] <= sc_ret_s[c];
                    if (sc_ret_v[0]) done_seq <= sc_last_s;
                    trap_valid   <= sc_trap_v;
                    trap_seq     <= sc_trap_s;
                    branch_count <= branch_count + BR_W'(sc_n_br);
                    if (sc_rel_v) begin
                        rel_valid <= 1'b1;
                        rel_seq   <= sc_rel_s;
                        mem[head_idx + IDX_W'(sc_rel_off)].can_commit <= 1'b0;
                    end
                    for (int k = 0; k < RENAME_W; k++) begin
                        if (ins_en[k]) begin
                            mem[ins_idx[k]] <= '{valid: 1'b1, killed: 1'b0,
                                can_commit: disp_nonspec[k], executed: 1'b0,
                                nonspec: disp_nonspec[k], ctrl: disp_ctrl[k],
                                fault: disp_fault[k], seq: disp_seq[k*SEQ_W +: SEQ_W]};
                        end
                    end
                    tail_q <= tail_q + PTR_W'(n_ins);
                end
            end else begin
                if (w_rm == '0) begin
                    state_q <= ST_RUN; bk_squashing <= 1'b0;
                end else begin
                    tail_q <= tail_q - PTR_W'(w_rm);
                    for (int j = 0; j < WALK_W; j++)
                        if (j < int'(w_rm)) mem[tail_idx - IDX_W'(j+1)].valid <= 1'b0;
                    done_seq <= w_tail_s;
                end
            end
            // Completion marking runs in every state
            for (int e = 0; e < DEPTH; e++) begin
                for (int k = 0; k < EXEC_W; k++) begin
                    if (cpl_valid[k] && mem[e].valid && mem[e].seq == cpl_seq[k*SEQ_W +: SEQ_W]) begin
                        mem[e].can_commit <= 1'b1;
                        mem[e].executed   <= 1'b1;
                        if (cpl_kill[k]) mem[e].killed <= 1'b1;
                    end
                end
            end
        end
    end

    // Assertions
    assert_ret_order_R1: assert property (@(posedge clk) disable iff (rst)
        ret_valid[1] |-> (ret_valid[0] && (ret_seq[2*SEQ_W-1:SEQ_W] > ret_seq[SEQ_W-1:0])));

    assert_release_once_R3: assert property (@(posedge clk) disable iff (rst)
        rel_valid |=> !rel_valid);

    assert_squash_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && sq_req) |=> (bk_squash && bk_squashing && done_seq == $past(sq_seq)));

    assert_walk_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SQUASH) |=> (ret_valid == '0 && occ <= $past(occ)));

    assert_ready_room_R6: assert property (@(posedge clk) disable iff (rst)
        disp_ready |-> (free_count >= PTR_W'(RENAME_W)));

    assert_free_bound_R8: assert property (@(posedge clk) disable iff (rst)
        free_count <= PTR_W'(DEPTH));

endmodule

// File: tb/test_rob_retire_top.sv
module test_rob_retire_top;
    import rob_pkg::*;

    logic clk = 0, rst = 1;
    always #4 clk = ~clk;

    logic [1:0]  disp_valid = 0, disp_skip = 0, disp_nonspec = 0, disp_ctrl = 0, disp_fault = 0;
    logic [31:0] disp_seq = 0;
    logic        disp_ready;
    logic [1:0]  cpl_valid = 0, cpl_kill = 0;
    logic [31:0] cpl_seq = 0;
    logic        sq_req = 0, sq_mispred = 0, sq_taken = 0;
    logic [15:0] sq_seq = 0;
    logic [31:0] sq_next_pc = 0, sq_bad_pc = 0;
    logic [1:0]  ret_valid;
    logic [31:0] ret_seq;
    logic        trap_valid, rel_valid;
    logic [15:0] trap_seq, rel_seq, branch_count, done_seq;
    logic [4:0]  free_count;
    logic        bk_squash, bk_squashing, bk_mispred, bk_taken;
    logic [31:0] bk_next_pc, bk_bad_pc;

    rob_retire_top i_rob_retire_top (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_seq(disp_seq),
        .disp_skip(disp_skip), .disp_nonspec(disp_nonspec), .disp_ctrl(disp_ctrl),
        .disp_fault(disp_fault), .disp_ready(disp_ready), .cpl_valid(cpl_valid),
        .cpl_seq(cpl_seq), .cpl_kill(cpl_kill), .sq_req(sq_req), .sq_seq(sq_seq),
        .sq_mispred(sq_mispred), .sq_taken(sq_taken), .sq_next_pc(sq_next_pc),
        .sq_bad_pc(sq_bad_pc), .ret_valid(ret_valid), .ret_seq(ret_seq),
        .trap_valid(trap_valid), .trap_seq(trap_seq), .rel_valid(rel_valid),
        .rel_seq(rel_seq), .branch_count(branch_count), .free_count(free_count),
        .done_seq(done_seq), .bk_squash(bk_squash), .bk_squashing(bk_squashing),
        .bk_mispred(bk_mispred), .bk_taken(bk_taken), .bk_next_pc(bk_next_pc),
        .bk_bad_pc(bk_bad_pc)
    );

    int   n_cmp = 0, n_mis = 0;
    seq_t exp_q [$];
    seq_t seq_next = 1;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: every retired instruction must match the reference order
    always @(negedge clk) begin
        if (!rst) begin
            if (ret_valid == 2'b10) chk("R1 slot1 without slot0", ret_valid, 2'b11);
            for (int s = 0; s < 2; s++) begin
                if (ret_valid[s]) begin
                    if (exp_q.size() == 0) chk("R1 unexpected retire", ret_seq[s*16 +: 16], 0);
                    else chk("R1 retire order", ret_seq[s*16 +: 16], exp_q.pop_front());
                end
            end
        end
    end

    task automatic dispatch(input logic [1:0] v, input logic [1:0] skip,
                            input logic [1:0] ns, input logic [1:0] ct, input logic [1:0] ft);
        for (int k = 0; k < 2; k++) begin
            if (v[k]) begin
                disp_seq[k*16 +: 16] = seq_next;
                if (!skip[k]) exp_q.push_back(seq_next);
                seq_next++;
            end
        end
        disp_valid = v; disp_skip = skip; disp_nonspec = ns; disp_ctrl = ct; disp_fault = ft;
        @(negedge clk);
        disp_valid = 0; disp_skip = 0; disp_nonspec = 0; disp_ctrl = 0; disp_fault = 0;
    endtask

    task automatic complete(input seq_t a, input logic va, input seq_t b, input logic vb,
                            input logic [1:0] kill);
        cpl_valid = {vb, va}; cpl_seq = {b, a}; cpl_kill = kill;
        for (int k = 0; k < 2; k++) begin
            if (kill[k]) begin
                for (int i = 0; i < exp_q.size(); i++)
                    if (exp_q[i] == (k == 0 ? a : b)) begin exp_q.delete(i); break; end
            end
        end
        @(negedge clk);
        cpl_valid = 0; cpl_kill = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        seq_t s;
        logic [15:0] br0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        chk("R10 free", free_count, 16);
        chk("R10 ready", disp_ready, 1);
        chk("R10 ret", ret_valid, 0);
        chk("R10 squashing", bk_squashing, 0);
        chk("R10 done", done_seq, 0);
        chk("R10 branches", branch_count, 0);

        // R1: head not ready blocks, then two per cycle in order
        dispatch(2'b11, 0, 0, 0, 0);
        dispatch(2'b11, 0, 0, 0, 0);
        complete(3, 1, 4, 1, 0);
        repeat (2) @(negedge clk);
        chk("R1 blocked head", ret_valid, 0);
        chk("R8 free four held", free_count, 12);
        complete(1, 1, 2, 1, 0);
        @(negedge clk);
        chk("R1 first pair", ret_valid, 2'b11);
        chk("R1 first pair slot0", ret_seq[15:0], 1);
        @(negedge clk);
        chk("R1 second pair", ret_valid, 2'b11);
        chk("R8 done after retire", done_seq, 4);
        chk("R8 free refilled", free_count, 16);

        // R6: skipped slot takes no entry
        dispatch(2'b11, 2'b01, 0, 0, 0);
        chk("R6 skip free", free_count, 15);
        dispatch(2'b10, 0, 0, 0, 0);
        chk("R6 single slot1 free", free_count, 14);
        complete(6, 1, 7, 1, 0);
        repeat (2) @(negedge clk);
        chk("R8 done seq 7", done_seq, 7);
        chk("R6 drained", free_count, 16);

        // R2: killed head drained without using commit bandwidth
        br0 = branch_count;
        s = seq_next;
        dispatch(2'b11, 0, 0, 2'b01, 2'b01);
        dispatch(2'b11, 0, 0, 0, 0);
        complete(s+2, 1, s+3, 1, 0);
        @(negedge clk);
        chk("R1 killed-to-be head blocks", ret_valid, 0);
        complete(s, 1, s+1, 1, 2'b01);
        @(negedge clk);
        chk("R2 two real retire", ret_valid, 2'b11);
        chk("R2 slot0 seq", ret_seq[15:0], s+1);
        chk("R2 slot1 seq", ret_seq[31:16], s+2);
        chk("R2 no trap from killed", trap_valid, 0);
        chk("R2 free after drain", free_count, 15);
        @(negedge clk);
        chk("R2 last one", ret_valid, 2'b01);
        chk("R2 no branch from killed", branch_count, br0);

        // R3: non-speculative release
        s = seq_next;
        dispatch(2'b01, 0, 2'b01, 0, 0);
        @(negedge clk);
        chk("R3 release pulse", rel_valid, 1);
        chk("R3 release seq", rel_seq, s);
        @(negedge clk);
        chk("R3 single pulse", rel_valid, 0);
        chk("R3 not retired", ret_valid, 0);
        chk("R3 still held", free_count, 15);
        complete(s, 1, 0, 0, 0);
        @(negedge clk);
        chk("R3 retires after completion", ret_valid, 2'b01);
        chk("R8 done after release", done_seq, s);

        // R9: trap and branch count
        br0 = branch_count;
        s = seq_next;
        dispatch(2'b11, 0, 0, 2'b01, 2'b10);
        complete(s, 1, s+1, 1, 0);
        @(negedge clk);
        chk("R9 both retire", ret_valid, 2'b11);
        chk("R9 trap", trap_valid, 1);
        chk("R9 trap seq", trap_seq, s+1);
        chk("R9 branch count", branch_count, br0 + 1);

        // R6: ready falls when full
        s = seq_next;
        for (int g = 0; g < 7; g++) dispatch(2'b11, 0, 0, 0, 0);
        chk("R6 ready with two free", disp_ready, 1);
        chk("R8 two free", free_count, 2);
        dispatch(2'b11, 0, 0, 0, 0);
        chk("R6 ready low when full", disp_ready, 0);
        chk("R8 full", free_count, 0);
        for (int g = 0; g < 8; g++) complete(s + seq_t'(2*g), 1, s + seq_t'(2*g+1), 1, 0);
        repeat (3) @(negedge clk);
        chk("R8 empty after burst", free_count, 16);
        chk("R8 done after burst", done_seq, s + 15);

        // R4, R5, R7: squash walk
        s = seq_next;
        for (int g = 0; g < 3; g++) dispatch(2'b11, 0, 0, 0, 0);
        sq_req = 1; sq_seq = s + 1; sq_mispred = 1; sq_taken = 0;
        sq_next_pc = 32'h1234; sq_bad_pc = 32'h1200;
        while (exp_q.size() > 0 && exp_q[exp_q.size()-1] > s + 1) void'(exp_q.pop_back());
        @(negedge clk);
        sq_req = 0;
        chk("R4 squash pulse", bk_squash, 1);
        chk("R4 squashing", bk_squashing, 1);
        chk("R4 done is squash point", done_seq, s + 1);
        chk("R4 mispred", bk_mispred, 1);
        chk("R4 taken", bk_taken, 0);
        chk("R4 next pc", bk_next_pc, 32'h1234);
        chk("R4 bad pc", bk_bad_pc, 32'h1200);
        chk("R6 ready low while squashing", disp_ready, 0);
        cpl_valid = 2'b01; cpl_seq = {16'd0, s};
        disp_valid = 2'b11; disp_seq = {16'd901, 16'd900};
        @(negedge clk);
        cpl_valid = 0; disp_valid = 0;
        chk("R5 walk step one", done_seq, s + 3);
        chk("R5 still squashing", bk_squashing, 1);
        chk("R4 pulse only once", bk_squash, 0);
        chk("R5 no commit in walk", ret_valid, 0);
        @(negedge clk);
        chk("R5 walk step two", done_seq, s + 1);
        @(negedge clk);
        chk("R5 walk over", bk_squashing, 0);
        chk("R5 survivors and no insert", free_count, 14);
        @(negedge clk);
        chk("R7 completed during walk retires", ret_valid, 2'b01);
        chk("R7 seq", ret_seq[15:0], s);
        complete(s + 1, 1, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk("R8 empty at end", free_count, 16);
        chk("R8 final done", done_seq, s + 1);
        chk("R1 all expected retired", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule